// File: doc/BRIEF.md
# Dual-Channel Converter Input Latch with Interleaved Demultiplexing

This block is the digital front end that feeds a pair of 14-bit converter cores. It presents two registered output words, one per core. Each channel has two stages. A capture register accepts a data word when a write strobe rises. An output register then takes the captured word when an update strobe rises. All strobes are plain levels that are sampled in one fast system clock domain. An edge is the cycle in which a strobe is high after being low in the cycle before.

A mode input selects how the strobe pins are used. In dual mode the two channels are fully independent: each has its own data port, write strobe and update strobe. In interleaved mode only port A carries data, as an alternating stream of I and Q words, and the four strobe pins take new roles:

- The A write strobe becomes the shared write.
- The B write strobe becomes the channel select.
- The A update strobe becomes the shared update clock.
- The B update strobe becomes the divider reset.

A three-state divider (`DV_SYNC`, `DV_LOAD`, `DV_SKIP`) halves the shared update clock. It loads both output registers together. The divider reset realigns it so that the first update edge after the reset is released always loads. A sleep input blanks both outputs without losing the stored data.

Top module: `iq_dac_frontend`

## Requirements
- R1: While `rst_n` is low, and directly after reset, both capture registers and both output registers hold zero, both output words read zero, and the divider is in `DV_SYNC`.
- R2: In dual mode (`mode_dual`=1), a rising edge of `a_wr` or `b_wr` captures that channel's own data port (`a_data` or `b_data`) into its capture register. The output word does not change on that edge.
- R3: In dual mode, a rising edge of `a_ck` or `b_ck` copies that channel's capture register into its output register, and the new value is visible one clock later. The other channel is not affected.
- R4: When an update edge and a write edge fall in the same cycle on one channel, the output register takes the capture register's previous contents. The new word appears only on a later update edge.
- R5: A strobe held high for several cycles counts as a single edge. Data that changes while the strobe stays high is not captured.
- R6: In interleaved mode (`mode_dual`=0), a rising edge of `a_wr` captures `a_data` into channel A when `b_wr` is 1, and into channel B when `b_wr` is 0. `b_data` is ignored.
- R7: In interleaved mode, while `b_ck` (divider reset) is high, edges on `a_ck` change neither output register, and the divider is held in `DV_SYNC`.
- R8: In interleaved mode with `b_ck` low, the first `a_ck` edge after `DV_SYNC` loads both output registers in the same cycle (transition `DV_SYNC`→`DV_SKIP`, or `DV_LOAD`→`DV_SKIP`). The next edge loads nothing (`DV_SKIP`→`DV_LOAD`), and loading continues on every second edge after that. In dual mode the divider stays in `DV_SYNC`.
- R9: While `sleep_req` is 1, both output words read zero, and writes and updates still proceed. When `sleep_req` returns to 0 (its enabled level), the stored output words reappear.
- R10: Words are 14-bit straight binary with bit 13 as MSB. All 14 bits pass unchanged from port to output, including 0x3FFF and 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dual | input | 1 | 1: two independent channels; 0: interleaved stream on port A |
| sleep_req | input | 1 | 1 blanks both output words; 0 enables them |
| a_data | input | 14 | Channel A data port (the interleaved stream in mode 0) |
| b_data | input | 14 | Channel B data port (unused in mode 0) |
| a_wr | input | 1 | Dual: channel A write strobe. Interleaved: shared write |
| a_ck | input | 1 | Dual: channel A update strobe. Interleaved: shared update clock |
| b_wr | input | 1 | Dual: channel B write strobe. Interleaved: channel select (1 = A) |
| b_ck | input | 1 | Dual: channel B update strobe. Interleaved: divider reset (active high) |
| a_word | output | 14 | Channel A output word to the converter core |
| b_word | output | 14 | Channel B output word to the converter core |

## Verification
The properties assume that every strobe and data pin changes only between clock edges and is constant across each sampling edge. In other words, they assume the external strobes have already been brought into the system clock domain. They also assume that the mode input is a quasi-static level, so that a cycle in which the mode changes is judged under the new mode. The stimulus changes all inputs one time unit after a rising edge. In interleaved stretches, the stimulus raises the divider reset only rarely, so that long runs of divide-by-two alternation are covered, and a directed sequence checks the realignment after the reset is released.

// File: rtl/iqdac_pkg.sv
package iqdac_pkg;
    parameter int unsigned WORD_W = 14;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned NUM_STROBE = 2 * NUM_CH;

    typedef enum logic [1:0] {
        DV_SYNC = 2'd0,
        DV_LOAD = 2'd1,
        DV_SKIP = 2'd2
    } div_state_e;
endpackage

// File: rtl/iqdac_edge.sv
module iqdac_edge #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_det
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/iqdac_div.sv
module iqdac_div
    import iqdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       hold,
    input  logic       tick,
    output logic       load,
    output div_state_e state
);
    div_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DV_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable || hold) begin
            state_d = DV_SYNC;
        end else begin
            unique case (state_q)
                DV_SYNC: state_d = tick ? DV_SKIP : DV_LOAD;
                DV_LOAD: if (tick) state_d = DV_SKIP;
                DV_SKIP: if (tick) state_d = DV_LOAD;
                default: state_d = DV_SYNC;
            endcase
        end
    end

    always_comb begin
        load = 1'b0;
        if (enable && !hold && tick) begin
            unique case (state_q)
                DV_SYNC, DV_LOAD: load = 1'b1;
                DV_SKIP:          load = 1'b0;
                default:          load = 1'b0;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/iqdac_chan.sv
module iqdac_chan #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         cap,
    input  logic         upd,
    input  logic         blank,
    output logic [W-1:0] held,
    output logic [W-1:0] stage,
    output logic [W-1:0] dout
);
    logic [W-1:0] cap_q, out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            out_q <= '0;
        end else begin
            if (cap) cap_q <= din;
            if (upd) out_q <= cap_q;
        end
    end

    assign held  = cap_q;
    assign stage = out_q;
    assign dout  = blank ? '0 : out_q;
endmodule

// File: rtl/iq_dac_frontend.sv
module iq_dac_frontend
    import iqdac_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_dual,
    input  logic         sleep_req,
    input  logic [W-1:0] a_data,
    input  logic [W-1:0] b_data,
    input  logic         a_wr,
    input  logic         a_ck,
    input  logic         b_wr,
    input  logic         b_ck,
    output logic [W-1:0] a_word,
    output logic [W-1:0] b_word
);
    localparam int unsigned SA_WR = 0;
    localparam int unsigned SA_CK = 1;
    localparam int unsigned SB_WR = 2;
    localparam int unsigned SB_CK = 3;

    logic [NUM_STROBE-1:0] lvl, rise;
    logic                  div_load;
    div_state_e            div_state;

    logic [W-1:0] ch_din   [NUM_CH];
    logic [W-1:0] ch_held  [NUM_CH];
    logic [W-1:0] ch_stage [NUM_CH];
    logic [W-1:0] ch_dout  [NUM_CH];
    logic [NUM_CH-1:0] ch_cap, ch_upd;

    assign lvl = {b_ck, b_wr, a_ck, a_wr};

    iqdac_edge #(.N(NUM_STROBE)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    iqdac_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(!mode_dual),
        .hold  (b_ck),
        .tick  (rise[SA_CK]),
        .load  (div_load),
        .state (div_state)
    );

    always_comb begin
        if (mode_dual) begin
            ch_din[0] = a_data;
            ch_din[1] = b_data;
            ch_cap    = {rise[SB_WR], rise[SA_WR]};
            ch_upd    = {rise[SB_CK], rise[SA_CK]};
        end else begin
            ch_din[0] = a_data;
            ch_din[1] = a_data;
            ch_cap    = {rise[SA_WR] & ~b_wr, rise[SA_WR] & b_wr};
            ch_upd    = {div_load, div_load};
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        iqdac_chan #(.W(W)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ch_din[c]),
            .cap  (ch_cap[c]),
            .upd  (ch_upd[c]),
            .blank(sleep_req),
            .held (ch_held[c]),
            .stage(ch_stage[c]),
            .dout (ch_dout[c])
        );
    end

    assign a_word = ch_dout[0];
    assign b_word = ch_dout[1];
endmodule

// File: rtl/iqdac_checker.sv
module iqdac_checker
    import iqdac_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_dual,
    input logic         sleep_req,
    input logic [W-1:0] a_data,
    input logic         a_wr,
    input logic         a_ck,
    input logic         b_ck,
    input logic [W-1:0] a_word,
    input logic [W-1:0] b_word,
    input logic [W-1:0] held_b,
    input logic [W-1:0] stage_a,
    input logic [W-1:0] stage_b,
    input logic         ck_rise,
    input div_state_e   state
);
    a_r9_sleep_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (a_word == '0 && b_word == '0));

    a_r7_reset_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && b_ck) |=> ($stable(stage_a) && $stable(stage_b)));

    a_r7_reset_syncs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && b_ck) |=> (state == DV_SYNC));

    a_r8_first_edge_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && !b_ck && state == DV_SYNC && ck_rise) |=> (state == DV_SKIP));

    a_r8_dual_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dual |=> (state == DV_SYNC));

    a_r6_port_a_only: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dual |=> (held_b == $past(held_b) || held_b == $past(a_data)));

    a_r2_write_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && a_wr && !a_ck) |=> $stable(stage_a));
endmodule

bind iq_dac_frontend iqdac_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_dual(mode_dual),
    .sleep_req(sleep_req),
    .a_data   (a_data),
    .a_wr     (a_wr),
    .a_ck     (a_ck),
    .b_ck     (b_ck),
    .a_word   (a_word),
    .b_word   (b_word),
    .held_b   (ch_held[1]),
    .stage_a  (ch_stage[0]),
    .stage_b  (ch_stage[1]),
    .ck_rise  (rise[1]),
    .state    (div_state)
);

// File: tb/sim_iq_dac_frontend.sv
module sim_iq_dac_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_dual = 1'b1;
    logic        sleep_req = 1'b0;
    logic [13:0] a_data = '0, b_data = '0;
    logic        a_wr = 1'b0, a_ck = 1'b0, b_wr = 1'b0, b_ck = 1'b0;
    logic [13:0] a_word, b_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference state
    logic [3:0]  m_prev;
    logic [13:0] m_in1, m_in2, m_out1, m_out2;
    int          m_phase; // 0 sync, 1 next edge loads, 2 next edge skipped

    always #2 clk = ~clk;

    iq_dac_frontend u0 (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .sleep_req(sleep_req),
        .a_data(a_data), .b_data(b_data), .a_wr(a_wr), .a_ck(a_ck),
        .b_wr(b_wr), .b_ck(b_ck), .a_word(a_word), .b_word(b_word)
    );

    function automatic logic [13:0] shown(logic [13:0] v);
        return sleep_req ? 14'd0 : v;
    endfunction

    task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_prev = '0; m_in1 = '0; m_in2 = '0; m_out1 = '0; m_out2 = '0; m_phase = 0;
    endtask

    task automatic model_step();
        logic [3:0] cur, e;
        logic c1, c2, u1, u2;
        logic [13:0] d2;
        cur = {b_ck, b_wr, a_ck, a_wr};
        e = cur & ~m_prev;
        m_prev = cur;
        if (mode_dual) begin
            c1 = e[0]; u1 = e[1]; c2 = e[2]; u2 = e[3]; d2 = b_data; m_phase = 0;
        end else begin
            c1 = e[0] & b_wr; c2 = e[0] & ~b_wr; d2 = a_data;
            u1 = 1'b0;
            if (b_ck) m_phase = 0;
            else if (e[1]) begin
                if (m_phase != 2) begin u1 = 1'b1; m_phase = 2; end
                else m_phase = 1;
            end else if (m_phase == 0) m_phase = 1;
            u2 = u1;
        end
        if (u1) m_out1 = m_in1;
        if (u2) m_out2 = m_in2;
        if (c1) m_in1 = a_data;
        if (c2) m_in2 = d2;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        chk(tag, a_word, shown(m_out1));
        chk(tag, b_word, shown(m_out2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", a_word, 14'd0);
        chk("R1", b_word, 14'd0);
        rst_n = 1'b1;
        tick();
        chk("R1", a_word, 14'd0);

        // R2: write captures, output unchanged
        tag = "R2";
        a_data = 14'h2AAA; a_wr = 1'b1; tick();
        chk("R2", a_word, 14'h0000);
        a_wr = 1'b0; tick();
        // R3: update copies
        tag = "R3";
        a_ck = 1'b1; tick();
        chk("R3", a_word, 14'h2AAA);
        chk("R3", b_word, 14'h0000);
        a_ck = 1'b0; tick();

        // R4: update and write together
        tag = "R4";
        a_data = 14'h1234; a_wr = 1'b1; a_ck = 1'b1; tick();
        chk("R4", a_word, 14'h2AAA);
        a_wr = 1'b0; a_ck = 1'b0; tick();
        a_ck = 1'b1; tick();
        chk("R4", a_word, 14'h1234);
        a_ck = 1'b0; tick();

        // R5: held strobe, data change ignored; R10 all ones
        tag = "R5";
        a_data = 14'h3FFF; a_wr = 1'b1; tick();
        a_data = 14'h0001; tick(); tick();
        a_wr = 1'b0; tick();
        a_ck = 1'b1; tick();
        chk("R5", a_word, 14'h3FFF);
        chk("R10", a_word, 14'h3FFF);
        a_ck = 1'b0; tick();

        // channel B, MSB only
        tag = "R10";
        b_data = 14'h2000; b_wr = 1'b1; tick();
        b_wr = 1'b0; tick();
        b_ck = 1'b1; tick();
        chk("R10", b_word, 14'h2000);
        chk("R3", a_word, 14'h3FFF);
        b_ck = 1'b0; tick();

        // R9: sleep blanks, state kept
        tag = "R9";
        sleep_req = 1'b1; tick();
        chk("R9", a_word, 14'h0000);
        chk("R9", b_word, 14'h0000);
        b_data = 14'h0555; b_wr = 1'b1; tick();
        b_wr = 1'b0; tick();
        sleep_req = 1'b0; tick();
        chk("R9", b_word, 14'h2000);
        chk("R9", a_word, 14'h3FFF);
        b_ck = 1'b1; tick();
        chk("R9", b_word, 14'h0555);
        b_ck = 1'b0; tick();

        // interleaved mode
        tag = "R6";
        mode_dual = 1'b0; b_ck = 1'b1; tick();
        b_data = 14'h3333;
        a_data = 14'h0111; b_wr = 1'b1; a_wr = 1'b1; tick();
        a_wr = 1'b0; tick();
        a_data = 14'h0222; b_wr = 1'b0; a_wr = 1'b1; tick();
        a_wr = 1'b0; tick();
        tag = "R7";
        a_ck = 1'b1; tick();
        chk("R7", a_word, 14'h3FFF);
        chk("R7", b_word, 14'h0555);
        a_ck = 1'b0; tick();
        b_ck = 1'b0; tick();
        tag = "R8";
        a_ck = 1'b1; tick();
        chk("R8", a_word, 14'h0111);
        chk("R6", b_word, 14'h0222);
        a_ck = 1'b0; tick();
        a_data = 14'h0AAA; b_wr = 1'b1; a_wr = 1'b1; tick();
        a_wr = 1'b0; tick();
        a_ck = 1'b1; tick();
        chk("R8", a_word, 14'h0111);
        a_ck = 1'b0; tick();
        a_ck = 1'b1; tick();
        chk("R8", a_word, 14'h0AAA);
        chk("R8", b_word, 14'h0222);
        a_ck = 1'b0; tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) mode_dual = ~mode_dual;
            tag = mode_dual ? "R3" : "R8";
            a_data = 14'($urandom);
            b_data = 14'($urandom);
            if ($urandom % 3 == 0) a_wr = ~a_wr;
            if ($urandom % 3 == 0) a_ck = ~a_ck;
            if ($urandom % 3 == 0) b_wr = ~b_wr;
            if (mode_dual) begin
                if ($urandom % 3 == 0) b_ck = ~b_ck;
            end else begin
                b_ck = ($urandom % 24 == 0);
            end
            sleep_req = ($urandom % 20 == 0);
            tick();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule